// File: doc/BRIEF.md
# MDIO Management Slave with Interrupt Register

This block is the device-side end of a Clause 22 serial management link. It watches the management clock and data lines as ordinary inputs on the local clock. It recognises read and write frames addressed to its strapped device address. On a read it takes over the data line for the turnaround and the 16 data bits. Behind the serial port sits a 32-entry, 16-bit register file. Writes land in it, and reads return it.

One register slot is an interrupt register. Its upper byte holds enables that software can write. Its lower byte holds event flags. Event inputs set these flags, and reading the register clears them. A bit in the configuration slot sets the polarity of the interrupt output. The output is active low by default.

Frames that are not well formed do not touch the register file or the data line. This covers a short preamble, a bad start code, an unknown opcode and a foreign device address. After such a frame the slave waits for a fresh preamble before it accepts anything.

Top module: `mdio_slave`

## Requirements
- R1: After reset every register reads 0, the data line is not driven (mdio_oe_o = 0) and int_o is 1 (inactive, active-low default).
- R2: A write frame (start 01, opcode 01, turnaround 10, 16 data bits MSB first) to a matching address stores the data in the addressed register, and the slave never drives the data line during it.
- R3: On a read frame (opcode 10) to a matching address, the slave leaves the first turnaround bit undriven. It drives 0 for the second, drives the 16 data bits MSB first, and releases the line after the last data bit. Each value is changed just after a rising MDC edge, so the master samples it on the next rising edge.
- R4: The 5-bit device address field matches only when its top two bits are 0 and its low three bits equal phy_addr_i. Address 0 is an ordinary address and is honoured only when the strap is 0. Non-matching frames cause neither a write nor any drive.
- R5: A frame whose start code is not 01, or whose opcode is 00 or 11, is ignored in full.
- R6: Fewer than 32 consecutive ones before the start code leave the frame ignored.
- R7: In register 0x1B, bits [15:8] are enables that writes set. Bits [7:0] are status flags, each set by the matching event_i bit. Writes do not change the status flags.
- R8: Reading register 0x1B returns the enables and flags as they were before the read, then clears the flags. An event active in the clearing cycle leaves its flag set.
- R9: The interrupt is pending when some flag and its enable are both 1. int_o is low when pending and high otherwise while bit 14 of register 0x1F is 0. It is high when pending and low otherwise while that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock; MDC and MDIO are sampled on it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdc_i | input | 1 | Management clock, already synchronous to clk_i |
| mdio_i | input | 1 | Management data as seen on the line |
| mdio_o | output | 1 | Data driven by the slave |
| mdio_oe_o | output | 1 | Output enable for mdio_o (1 = slave drives) |
| phy_addr_i | input | 3 | Strapped device address |
| event_i | input | 8 | Interrupt event inputs, one per status flag |
| int_o | output | 1 | Interrupt output, polarity from register 0x1F bit 14 |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble, 32 registers of 16 bits, the interrupt register at 0x1B and the polarity bit at 0x1F[14]. This makes the exact preamble boundary (31 against 32 ones) and all eight event lines reachable. The strap input is moved between 5 and 0 at run time. This exercises address 0 both as a foreign address and as the device's own. It also exercises an address that matches only in its low bits.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  typedef enum logic [2:0] {ST_PRE, ST_SOF, ST_HDR, ST_TA, ST_DAT} mdio_st_e;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam int PA_W = 5;
endpackage

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int STRAP_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mdc_i,
  input  logic               mdio_i,
  input  logic [STRAP_W-1:0] phy_addr_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic [REG_AW-1:0]  rd_addr_o,
  output logic               rd_en_o,
  output logic               wr_en_o,
  output logic [REG_AW-1:0]  acc_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               mdio_o,
  output logic               mdio_oe_o
);
  localparam int HDR_W = 2 + PA_W + REG_AW;
  localparam int CW0   = $clog2(PRE_LEN + 1);
  localparam int CW1   = $clog2(HDR_W);
  localparam int CW2   = $clog2(DATA_W);
  localparam int CW01  = (CW0 > CW1) ? CW0 : CW1;
  localparam int CW    = (CW01 > CW2) ? CW01 : CW2;

  mdio_st_e          state_q;
  logic [CW-1:0]     cnt_q;
  logic [HDR_W-1:0]  hdr_q, hdr_nxt;
  logic [DATA_W-1:0] dsh_q;
  logic [REG_AW-1:0] ra_q;
  logic              mdc_q, rise, is_rd_q, rd_en_q, wr_en_q, oe_q, out_q;
  logic [1:0]        op;
  logic [PA_W-1:0]   pa;
  logic              addr_hit, op_ok;

  assign rise      = mdc_i & ~mdc_q;
  assign hdr_nxt   = {hdr_q[HDR_W-2:0], mdio_i};
  assign op        = hdr_nxt[HDR_W-1 -: 2];
  assign pa        = hdr_nxt[REG_AW +: PA_W];
  assign rd_addr_o = hdr_nxt[REG_AW-1:0];
  assign addr_hit  = (pa[PA_W-1:STRAP_W] == '0) && (pa[STRAP_W-1:0] == phy_addr_i);
  assign op_ok     = (op == OP_RD) || (op == OP_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PRE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      dsh_q   <= '0;
      ra_q    <= '0;
      mdc_q   <= 1'b0;
      is_rd_q <= 1'b0;
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      mdc_q   <= mdc_i;
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      if (rise) begin
        unique case (state_q)
          ST_PRE: begin
            if (mdio_i) begin
              if (cnt_q != CW'(PRE_LEN)) cnt_q <= cnt_q + 1'b1;
            end else begin
              if (cnt_q == CW'(PRE_LEN)) state_q <= ST_SOF;
              cnt_q <= '0;
            end
          end
          ST_SOF: begin
            cnt_q   <= '0;
            state_q <= mdio_i ? ST_HDR : ST_PRE;
          end
          ST_HDR: begin
            hdr_q <= hdr_nxt;
            if (cnt_q == CW'(HDR_W - 1)) begin
              cnt_q <= '0;
              if (addr_hit && op_ok) begin
                state_q <= ST_TA;
                is_rd_q <= (op == OP_RD);
                ra_q    <= rd_addr_o;
                if (op == OP_RD) begin
                  dsh_q   <= rd_data_i;  // captured before the clear pulse lands
                  rd_en_q <= 1'b1;
                end
              end else begin
                state_q <= ST_PRE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_TA: begin
            if (cnt_q == '0) begin
              cnt_q <= CW'(1);
              if (is_rd_q) begin
                oe_q  <= 1'b1;
                out_q <= 1'b0;
              end
            end else begin
              cnt_q   <= '0;
              state_q <= ST_DAT;
              if (is_rd_q) begin
                out_q <= dsh_q[DATA_W-1];
                dsh_q <= {dsh_q[DATA_W-2:0], 1'b0};
              end
            end
          end
          ST_DAT: begin
            if (is_rd_q) begin
              out_q <= dsh_q[DATA_W-1];
              dsh_q <= {dsh_q[DATA_W-2:0], 1'b0};
            end else begin
              dsh_q <= {dsh_q[DATA_W-2:0], mdio_i};
            end
            if (cnt_q == CW'(DATA_W - 1)) begin
              state_q <= ST_PRE;
              cnt_q   <= '0;
              oe_q    <= 1'b0;
              out_q   <= 1'b0;
              wr_en_q <= ~is_rd_q;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_PRE;
        endcase
      end
    end
  end

  assign rd_en_o    = rd_en_q;
  assign wr_en_o    = wr_en_q;
  assign acc_addr_o = ra_q;
  assign wr_data_o  = dsh_q;
  assign mdio_o     = out_q;
  assign mdio_oe_o  = oe_q;

  p_ta_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);
  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> (state_q == ST_PRE));
  p_wr_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !mdio_oe_o);
  p_rd_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  p_hdr_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_PRE, ST_SOF, ST_HDR}) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs #(
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int IRQ_IDX = 27,
  parameter int CFG_IDX = 31,
  parameter int POL_BIT = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] irq_word_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pol_o
);
  localparam int REG_N = 1 << REG_AW;
  localparam logic [REG_AW-1:0] IRQ_A = REG_AW'(IRQ_IDX);

  logic [DATA_W-1:0] mem_q [REG_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_N; i++) mem_q[i] <= '0;
    end else if (wr_en_i && (wr_addr_i != IRQ_A)) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = (rd_addr_i == IRQ_A) ? irq_word_i : mem_q[rd_addr_i];
  assign pol_o     = mem_q[CFG_IDX][POL_BIT];

  p_cfg_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == REG_AW'(CFG_IDX))) |=> (pol_o == $past(wr_data_i[POL_BIT])));
endmodule

// File: rtl/mdio_irq.sv
module mdio_irq #(
  parameter int IRQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] event_i,
  input  logic             en_we_i,
  input  logic [IRQ_W-1:0] en_d_i,
  input  logic             clr_i,
  input  logic             pol_i,
  output logic [IRQ_W-1:0] en_o,
  output logic [IRQ_W-1:0] st_o,
  output logic             int_o
);
  logic [IRQ_W-1:0] en_q, st_q;
  logic             pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we_i) en_q <= en_d_i;
      st_q <= (clr_i ? '0 : st_q) | event_i;  // a coincident event outlives the clear
    end
  end

  assign pend  = |(en_q & st_q);
  assign int_o = pol_i ? pend : ~pend;
  assign en_o  = en_q;
  assign st_o  = st_q;

  p_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((st_o & $past(event_i)) == $past(event_i)));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (event_i == '0)) |=> (st_o == '0));
  p_en_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> (en_o == $past(en_o)));
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
  parameter int PRE_LEN = 32,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int STRAP_W = 3,
  parameter int IRQ_IDX = 27,
  parameter int CFG_IDX = 31,
  parameter int POL_BIT = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mdc_i,
  input  logic                mdio_i,
  output logic                mdio_o,
  output logic                mdio_oe_o,
  input  logic [STRAP_W-1:0]  phy_addr_i,
  input  logic [DATA_W/2-1:0] event_i,
  output logic                int_o
);
  localparam int IRQ_W = DATA_W / 2;
  localparam logic [REG_AW-1:0] IRQ_A = REG_AW'(IRQ_IDX);

  logic [REG_AW-1:0] rd_addr, acc_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              rd_en, wr_en, pol;
  logic [IRQ_W-1:0]  irq_en, irq_st;

  mdio_frame #(
    .PRE_LEN(PRE_LEN), .REG_AW(REG_AW), .DATA_W(DATA_W), .STRAP_W(STRAP_W)
  ) u_frame (
    .clk_i, .rst_ni, .mdc_i, .mdio_i, .phy_addr_i,
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .rd_en_o   (rd_en),
    .wr_en_o   (wr_en),
    .acc_addr_o(acc_addr),
    .wr_data_o (wr_data),
    .mdio_o, .mdio_oe_o
  );

  mdio_regs #(
    .REG_AW(REG_AW), .DATA_W(DATA_W), .IRQ_IDX(IRQ_IDX), .CFG_IDX(CFG_IDX), .POL_BIT(POL_BIT)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_addr_i (acc_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .irq_word_i({irq_en, irq_st}),
    .rd_data_o (rd_data),
    .pol_o     (pol)
  );

  mdio_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk_i, .rst_ni, .event_i,
    .en_we_i(wr_en && (acc_addr == IRQ_A)),
    .en_d_i (wr_data[DATA_W-1 -: IRQ_W]),
    .clr_i  (rd_en && (acc_addr == IRQ_A)),
    .pol_i  (pol),
    .en_o   (irq_en),
    .st_o   (irq_st),
    .int_o
  );
endmodule

// File: tb/mdio_slave_tb.sv
module mdio_slave_tb;
  logic       clk = 1'b0, rst_ni = 1'b0, mdc = 1'b0, mdio_in = 1'b1;
  logic [2:0] strap = 3'd5;
  logic [7:0] ev = '0;
  logic       mdio_out, mdio_oe, int_o;

  logic [15:0] mem [32];
  logic [7:0]  men, mst, hold;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdio_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mdc_i(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .phy_addr_i(strap),
    .event_i(ev), .int_o(int_o)
  );

  // Reference-model frame: drives bits, compares the slave's drive every MDC period.
  task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                       input string tag);
    logic q[$];
    logic good, rd, eoe, eo;
    logic [15:0] exp_d;
    int errs = 0;
    string first = "";
    good  = (pre >= 32) && (st == 2'b01) && (op == 2'b10 || op == 2'b01) && (pa == {2'b00, strap});
    rd    = good && (op == 2'b10);
    exp_d = (ra == 5'h1B) ? {men, mst} : mem[ra];
    q.push_back(1'b0);
    for (int i = 0; i < pre; i++) q.push_back(1'b1);
    for (int i = 1; i >= 0; i--) q.push_back(st[i]);
    for (int i = 1; i >= 0; i--) q.push_back(op[i]);
    for (int i = 4; i >= 0; i--) q.push_back(pa[i]);
    for (int i = 4; i >= 0; i--) q.push_back(ra[i]);
    q.push_back(1'b1);
    q.push_back(op == 2'b01 ? 1'b0 : 1'b1);
    for (int i = 15; i >= 0; i--) q.push_back(op == 2'b01 ? wd[i] : 1'b1);
    q.push_back(1'b1);
    for (int k = 0; k < q.size(); k++) begin
      int j;
      mdio_in = q[k];
      repeat (4) @(negedge clk);
      j = k - 1 - pre;
      eoe = 1'b0; eo = 1'b0;
      if (rd && j == 15) eoe = 1'b1;
      if (rd && j >= 16 && j < 32) begin eoe = 1'b1; eo = exp_d[31 - j]; end
      if (mdio_oe !== eoe || (eoe && mdio_out !== eo)) begin
        if (errs == 0) first = $sformatf("bit %0d oe=%b out=%b exp oe=%b out=%b", j, mdio_oe, mdio_out, eoe, eo);
        errs++;
      end
      mdc = 1'b1;
      repeat (4) @(negedge clk);
      mdc = 1'b0;
    end
    mdio_in = 1'b1;
    repeat (4) @(negedge clk);
    tests++;
    if (errs != 0) begin
      fails++;
      $display("FAIL %s: %s", tag, first);
    end
    if (good && op == 2'b01) begin
      if (ra == 5'h1B) men = wd[15:8];
      else mem[ra] = wd;
    end
    if (rd && ra == 5'h1B) mst = hold;
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] wd, input string tag);
    frame(32, 2'b01, 2'b01, {2'b00, strap}, ra, wd, tag);
  endtask

  task automatic rdc(input logic [4:0] ra, input string tag);
    frame(32, 2'b01, 2'b10, {2'b00, strap}, ra, 16'h0, tag);
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk) ev = m | hold;
    @(negedge clk) ev = hold;
    mst = mst | m;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_int(input string tag);
    logic pend, exp;
    pend = |(men & mst);
    exp  = mem[31][14] ? pend : ~pend;
    tests++;
    if (int_o !== exp) begin
      fails++;
      $display("FAIL %s: int_o=%b exp=%b", tag, int_o, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    men = '0; mst = '0; hold = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    tests++;  // R1 reset outputs
    if (mdio_oe !== 1'b0 || int_o !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: oe=%b int=%b exp oe=0 int=1", mdio_oe, int_o);
    end
    rdc(5'd3, "R1 reset read reg3");
    rdc(5'h1B, "R1 reset read irq reg");

    wr(5'd3, 16'hA5C3, "R2 write reg3");
    rdc(5'd3, "R2 R3 read reg3");
    wr(5'd0, 16'h8001, "R2 write reg0");
    rdc(5'd0, "R3 read reg0 edge bits");

    frame(32, 2'b01, 2'b01, 5'd0, 5'd3, 16'h1111, "R4 addr0 not broadcast");
    frame(32, 2'b01, 2'b01, 5'b01101, 5'd3, 16'h2222, "R4 upper addr bits");
    frame(32, 2'b01, 2'b10, 5'd4, 5'd3, 16'h0, "R4 foreign read no drive");
    rdc(5'd3, "R4 reg3 untouched");

    frame(32, 2'b00, 2'b01, 5'd5, 5'd3, 16'h3333, "R5 bad start");
    frame(32, 2'b01, 2'b11, 5'd5, 5'd3, 16'h4444, "R5 opcode 11");
    frame(32, 2'b01, 2'b00, 5'd5, 5'd3, 16'h5555, "R5 opcode 00");
    frame(31, 2'b01, 2'b01, 5'd5, 5'd3, 16'h6666, "R6 preamble 31");
    frame(31, 2'b01, 2'b10, 5'd5, 5'd3, 16'h0, "R6 short preamble read");
    rdc(5'd3, "R5 R6 reg3 untouched");

    strap = 3'd0;
    wr(5'd7, 16'h0F0F, "R4 strap0 write addr0");
    rdc(5'd7, "R4 strap0 read back");
    strap = 3'd5;

    pulse(8'h12);
    check_int("R9 flags without enables");
    rdc(5'h1B, "R7 flags visible");
    rdc(5'h1B, "R8 flags cleared by read");

    wr(5'h1B, 16'hFF55, "R7 write enables");
    rdc(5'h1B, "R7 enables set flags untouched");
    check_int("R9 enabled but idle");
    pulse(8'h01);
    check_int("R9 active low pending");
    rdc(5'h1B, "R8 read pending");
    check_int("R9 released after clear");

    wr(5'd31, 16'h4000, "R9 polarity high");
    check_int("R9 active high idle");
    pulse(8'h80);
    check_int("R9 active high pending");
    rdc(5'h1B, "R8 clear high pol");
    check_int("R9 active high cleared");

    hold = 8'h04;
    ev = hold;
    mst = mst | hold;
    repeat (3) @(negedge clk);
    rdc(5'h1B, "R8 read with held event");
    ev = '0;
    hold = '0;
    repeat (3) @(negedge clk);
    check_int("R8 held flag pending");
    rdc(5'h1B, "R8 held flag survived clear");

    wr(5'h1B, 16'h0200, "R7 partial enable");
    pulse(8'h01);
    check_int("R9 unmasked only");
    pulse(8'h02);
    check_int("R9 masked pending");

    done = 1;
    finish_run();
  end
endmodule